// File: doc/BRIEF.md
# Auxiliary I/O Control Register Block

This block is a small set of memory-mapped control registers that sits on a simple synchronous read/write port. A byte-wide region holds five 8-bit registers: configuration, auxiliary 1, auxiliary 2, diagnostic and modem control. Register addresses are decoded from address bits [27:16]. A separate select carries a write-only power-management strobe that asks the CPU to halt. A third select reaches a 32-bit system-control register, and only its word at offset 0 is implemented.

Auxiliary register 2 combines a power-fail flag, which hardware sets, with bits that software writes to clear that flag and to request a shutdown. The block brings the asynchronous power-fail input into the clock domain and reacts to each of its edges. It drives one level interrupt when a latched power fail meets the enable bit in the configuration register. The shutdown, system-reset and CPU-halt requests are one-clock pulses. The logic that acts on them lies outside this block. Reset clears only part of the register set.

Top module: `aux_ctrl_regs`

## Requirements
- R1: While bus_sel_i is high, address key addr_i[27:16] selects a byte register: 0x180 configuration, 0x190 auxiliary 1, 0x1A0 diagnostic, 0x1B0 modem control. A write stores all of wdata_i[7:0] on the clock edge, and a read returns that byte in rdata_o[7:0] with the upper bits zero.
- R2: A read returns zero when no register is selected. This covers an unknown key in the byte region, any read on pm_sel_i, and any system-control offset other than 0.
- R3: irq_o is high exactly when auxiliary-2 bit 2 (power fail) and configuration bit 3 (enable) are both set. It follows every write to either register.
- R4: pwr_fail_i passes through a two-flop synchroniser. A rising edge sets auxiliary-2 bit 2 if configuration bit 3 is set, and clears bit 2 otherwise. A falling edge clears bit 2.
- R5: A write to auxiliary 2 (key 0x191) takes only wdata_i[1:0] and keeps bit 2. If written bit 1 is set, bits 2 and 1 are cleared and only bit 0 remains. Bit 1 always reads back as zero.
- R6: A write to auxiliary 2 with wdata_i[0] set drives shutdown_req_o high for that write cycle only.
- R7: Any write while pm_sel_i is high drives halt_req_o high for that cycle only.
- R8: The active-low reset clears configuration, auxiliary 1, auxiliary 2 and modem control. The diagnostic and system-control registers keep their values through reset.
- R9: With sys_sel_i high, only addr_i[1:0]==0 is implemented. A write there with wdata_i[0] set loads the value 0x2 and pulses sys_reset_req_o for one cycle. A write with bit 0 clear, or a write to any other offset, changes nothing.
- R10: If a power-fail edge and an auxiliary-2 write with bit 1 set arrive in the same cycle, the software clear wins and bit 2 ends up zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Selects the byte register region |
| pm_sel_i | input | 1 | Selects the power-management strobe |
| sys_sel_i | input | 1 | Selects the system-control register |
| wr_en_i | input | 1 | High for a write, low for a read |
| addr_i | input | 28 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the selects and the address |
| pwr_fail_i | input | 1 | Asynchronous power-fail level |
| irq_o | output | 1 | Power-fail interrupt level |
| shutdown_req_o | output | 1 | Shutdown request pulse |
| sys_reset_req_o | output | 1 | System-reset request pulse |
| halt_req_o | output | 1 | CPU-halt request pulse |

## Verification
The bench builds the block with its default parameters: a 28-bit address, a 32-bit data path, a two-stage synchroniser and a system-control load value of 0x2. The two-stage synchroniser puts the power-fail edge a fixed, small number of cycles after the input changes. A burst of clearing writes can therefore be made to overlap the edge-detect cycle, which tests the same-cycle priority. With a 32-bit data path the system-control load value can be read back whole, and the bench can check that the upper byte-register bits read as zero.

// File: rtl/aux_ctrl_pkg.sv
package aux_ctrl_pkg;
  localparam int unsigned KEY_W = 12;
  localparam logic [KEY_W-1:0] KEY_CFG  = 12'h180;
  localparam logic [KEY_W-1:0] KEY_AUX1 = 12'h190;
  localparam logic [KEY_W-1:0] KEY_AUX2 = 12'h191;
  localparam logic [KEY_W-1:0] KEY_DIAG = 12'h1A0;
  localparam logic [KEY_W-1:0] KEY_MDM  = 12'h1B0;

  localparam int unsigned CFG_PF_EN_BIT   = 3;
  localparam int unsigned AUX2_PF_BIT     = 2;
  localparam int unsigned AUX2_CLR_BIT    = 1;
  localparam int unsigned AUX2_OFF_BIT    = 0;

  typedef struct packed {
    logic cfg;
    logic aux1;
    logic aux2;
    logic diag;
    logic mdm;
    logic pm;
    logic sys;
  } aux_hit_t;
endpackage

// File: rtl/aux_addr_decode.sv
module aux_addr_decode
  import aux_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 28,
  parameter int unsigned SYS_OFF_W = 2
) (
  input  logic              bus_sel_i,
  input  logic              pm_sel_i,
  input  logic              sys_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output aux_hit_t          hit_o
);
  localparam int unsigned KEY_LSB = ADDR_W - KEY_W;

  logic [KEY_W-1:0] key;
  logic [SYS_OFF_W-1:0] sys_off;
  logic [KEY_LSB-SYS_OFF_W-1:0] unused_mid;

  assign key        = addr_i[ADDR_W-1:KEY_LSB];
  assign sys_off    = addr_i[SYS_OFF_W-1:0];
  assign unused_mid = addr_i[KEY_LSB-1:SYS_OFF_W];

  always_comb begin
    hit_o      = '0;
    hit_o.cfg  = bus_sel_i && (key == KEY_CFG);
    hit_o.aux1 = bus_sel_i && (key == KEY_AUX1);
    hit_o.aux2 = bus_sel_i && (key == KEY_AUX2);
    hit_o.diag = bus_sel_i && (key == KEY_DIAG);
    hit_o.mdm  = bus_sel_i && (key == KEY_MDM);
    hit_o.pm   = pm_sel_i;
    hit_o.sys  = sys_sel_i && (sys_off == '0);
  end
endmodule

// File: rtl/aux_pf_sync.sv
module aux_pf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else if (g == 0) chain_q[g] <= async_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] && !prev_q;
  assign fall_o = !chain_q[STAGES-1] && prev_q;
endmodule

// File: rtl/aux_sysctrl.sv
module aux_sysctrl #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] LOAD_VAL = 32'h2
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic              hit_i,
  input  logic              go_i,
  output logic [DATA_W-1:0] q_o,
  output logic              req_o
);
  // Deliberately outside reset: the value survives a system reset it requests.
  logic [DATA_W-1:0] q;

  assign req_o = wr_en_i && hit_i && go_i;

  always_ff @(posedge clk_i) begin
    if (req_o) q <= LOAD_VAL;
  end

  assign q_o = q;
endmodule

// File: rtl/aux_ctrl_regs.sv
module aux_ctrl_regs
  import aux_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 28,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] SYS_LOAD_VAL = 32'h2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              pm_sel_i,
  input  logic              sys_sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pwr_fail_i,
  output logic              irq_o,
  output logic              shutdown_req_o,
  output logic              sys_reset_req_o,
  output logic              halt_req_o
);
  localparam int unsigned BYTE_W = 8;

  aux_hit_t hit;
  logic [BYTE_W-1:0] cfg_q, aux1_q, aux2_q, diag_q, mdm_q;
  logic [BYTE_W-1:0] aux2_d;
  logic [BYTE_W-1:0] wbyte;
  logic [DATA_W-1:0] sys_q;
  logic [DATA_W-BYTE_W-1:0] unused_wdata_hi;
  logic pf_rise, pf_fall, pf_bit;
  logic wr_aux2;

  assign wbyte           = wdata_i[BYTE_W-1:0];
  assign unused_wdata_hi = wdata_i[DATA_W-1:BYTE_W];

  aux_addr_decode #(.ADDR_W(ADDR_W), .SYS_OFF_W(2)) u_dec (
    .bus_sel_i (bus_sel_i),
    .pm_sel_i  (pm_sel_i),
    .sys_sel_i (sys_sel_i),
    .addr_i    (addr_i),
    .hit_o     (hit)
  );

  aux_pf_sync #(.STAGES(SYNC_STAGES)) u_pf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pwr_fail_i),
    .rise_o  (pf_rise),
    .fall_o  (pf_fall)
  );

  aux_sysctrl #(.DATA_W(DATA_W), .LOAD_VAL(SYS_LOAD_VAL)) u_sys (
    .clk_i   (clk_i),
    .wr_en_i (wr_en_i),
    .hit_i   (hit.sys),
    .go_i    (wbyte[0]),
    .q_o     (sys_q),
    .req_o   (sys_reset_req_o)
  );

  // Power-fail flag after hardware events; a software clear below overrides it.
  always_comb begin
    pf_bit = aux2_q[AUX2_PF_BIT];
    if (pf_rise)      pf_bit = cfg_q[CFG_PF_EN_BIT];
    else if (pf_fall) pf_bit = 1'b0;
  end

  assign wr_aux2 = wr_en_i && hit.aux2;

  always_comb begin
    aux2_d = aux2_q;
    aux2_d[AUX2_PF_BIT] = pf_bit;
    if (wr_aux2) begin
      aux2_d = '0;
      aux2_d[AUX2_OFF_BIT] = wbyte[AUX2_OFF_BIT];
      aux2_d[AUX2_PF_BIT]  = wbyte[AUX2_CLR_BIT] ? 1'b0 : pf_bit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      aux1_q <= '0;
      aux2_q <= '0;
      mdm_q  <= '0;
    end else begin
      if (wr_en_i && hit.cfg)  cfg_q  <= wbyte;
      if (wr_en_i && hit.aux1) aux1_q <= wbyte;
      if (wr_en_i && hit.mdm)  mdm_q  <= wbyte;
      aux2_q <= aux2_d;
    end
  end

  // Diagnostic byte keeps its content across reset.
  always_ff @(posedge clk_i) begin
    if (wr_en_i && hit.diag) diag_q <= wbyte;
  end

  assign irq_o          = aux2_q[AUX2_PF_BIT] && cfg_q[CFG_PF_EN_BIT];
  assign shutdown_req_o = wr_aux2 && wbyte[AUX2_OFF_BIT];
  assign halt_req_o     = wr_en_i && hit.pm;

  always_comb begin
    rdata_o = '0;
    if (hit.cfg)  rdata_o[BYTE_W-1:0] = cfg_q;
    if (hit.aux1) rdata_o[BYTE_W-1:0] = aux1_q;
    if (hit.aux2) rdata_o[BYTE_W-1:0] = aux2_q;
    if (hit.diag) rdata_o[BYTE_W-1:0] = diag_q;
    if (hit.mdm)  rdata_o[BYTE_W-1:0] = mdm_q;
    if (hit.sys)  rdata_o = sys_q;
  end
endmodule

// File: rtl/aux_ctrl_regs_chk.sv
module aux_ctrl_regs_chk #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] LOAD_VAL = 32'h2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              pm_sel_i,
  input logic              hit_cfg,
  input logic              hit_aux2,
  input logic [3:0]        wlow,
  input logic [7:0]        aux2_q,
  input logic [DATA_W-1:0] sys_q,
  input logic              irq_o,
  input logic              shutdown_req_o,
  input logic              sys_reset_req_o,
  input logic              halt_req_o
);
  p_cfg_disable_drops_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_cfg && !wlow[3]) |=> !irq_o);

  p_aux2_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_aux2 && wlow[1]) |=> (!irq_o && aux2_q[2:1] == 2'b00));

  p_shutdown_stores_bit0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_req_o |=> aux2_q[0]);

  p_halt_on_pm_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |-> (wr_en_i && pm_sel_i));

  p_sysrst_loads_value_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_req_o |=> (sys_q == LOAD_VAL));
endmodule

bind aux_ctrl_regs aux_ctrl_regs_chk #(.DATA_W(DATA_W), .LOAD_VAL(SYS_LOAD_VAL)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .pm_sel_i        (pm_sel_i),
  .hit_cfg         (hit.cfg),
  .hit_aux2        (hit.aux2),
  .wlow            (wdata_i[3:0]),
  .aux2_q          (aux2_q),
  .sys_q           (sys_q),
  .irq_o           (irq_o),
  .shutdown_req_o  (shutdown_req_o),
  .sys_reset_req_o (sys_reset_req_o),
  .halt_req_o      (halt_req_o)
);

// File: tb/aux_ctrl_regs_bench.sv
module aux_ctrl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;
  localparam logic [11:0] K_CFG = 12'h180, K_AUX1 = 12'h190, K_AUX2 = 12'h191,
                          K_DIAG = 12'h1A0, K_MDM = 12'h1B0;
  localparam int SEL_BUS = 0, SEL_PM = 1, SEL_SYS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, pm_sel = 0, sys_sel = 0, wr_en = 0, pf = 0;
  logic [27:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, shut, srst, halt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_ctrl_regs u_aux_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(bus_sel), .pm_sel_i(pm_sel),
    .sys_sel_i(sys_sel), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pwr_fail_i(pf), .irq_o(irq), .shutdown_req_o(shut),
    .sys_reset_req_o(srst), .halt_req_o(halt)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(int kind, logic [11:0] key, logic [1:0] off);
    bus_sel = (kind == SEL_BUS);
    pm_sel  = (kind == SEL_PM);
    sys_sel = (kind == SEL_SYS);
    addr    = (kind == SEL_SYS) ? {26'h0, off} : {key, 16'h0};
  endtask

  task automatic idle();
    bus_sel = 0; pm_sel = 0; sys_sel = 0; wr_en = 0; addr = '0; wdata = '0;
  endtask

  // Write: pulses sampled inside the write cycle, committed on the next posedge.
  task automatic wr(int kind, logic [11:0] key, logic [1:0] off, logic [31:0] d,
                    output logic [2:0] pulses);
    @(negedge clk);
    drive(kind, key, off);
    wr_en = 1; wdata = d;
    #Q pulses = {shut, srst, halt};
    @(negedge clk);
    idle();
  endtask

  task automatic rd(int kind, logic [11:0] key, logic [1:0] off, output logic [31:0] d);
    @(negedge clk);
    drive(kind, key, off);
    wr_en = 0;
    #Q d = rdata;
    idle();
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(SEL_BUS, K_CFG, 0, d);  chk("R8 cfg after reset", d, 0);
    rd(SEL_BUS, K_AUX2, 0, d); chk("R8 aux2 after reset", d, 0);
    #Q chk("R3 irq after reset", {31'b0, irq}, 0);
    chk("R6 R7 R9 pulses idle", {29'b0, shut, srst, halt}, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d; logic [2:0] p;
    wr(SEL_BUS, K_CFG, 0, 32'hFFFF_FFA5, p);
    wr(SEL_BUS, K_AUX1, 0, 32'h3C, p);
    wr(SEL_BUS, K_DIAG, 0, 32'h5A, p);
    wr(SEL_BUS, K_MDM, 0, 32'hC3, p);
    chk("R7 no halt on byte write", {29'b0, p}, 0);
    rd(SEL_BUS, K_CFG, 0, d);  chk("R1 cfg readback upper zero", d, 32'hA5);
    rd(SEL_BUS, K_AUX1, 0, d); chk("R1 aux1 readback", d, 32'h3C);
    rd(SEL_BUS, K_DIAG, 0, d); chk("R1 diag readback", d, 32'h5A);
    rd(SEL_BUS, K_MDM, 0, d);  chk("R1 mdm readback", d, 32'hC3);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(SEL_BUS, 12'h181, 0, d); chk("R2 unknown key", d, 0);
    rd(SEL_PM, 12'h0, 0, d);    chk("R2 pm read", d, 0);
    @(negedge clk); idle(); addr = {K_CFG, 16'h0};
    #Q chk("R2 no select", rdata, 0);
  endtask

  task automatic t_power_fail();
    logic [31:0] d; logic [2:0] p;
    wr(SEL_BUS, K_CFG, 0, 32'h08, p);
    pf = 1; wait_cycles(5);
    rd(SEL_BUS, K_AUX2, 0, d); chk("R4 rise with enable sets", d, 32'h04);
    #Q chk("R3 irq on", {31'b0, irq}, 1);
    wr(SEL_BUS, K_CFG, 0, 32'h00, p);
    #Q chk("R3 irq off when disabled", {31'b0, irq}, 0);
    rd(SEL_BUS, K_AUX2, 0, d); chk("R3 flag kept while disabled", d, 32'h04);
    wr(SEL_BUS, K_CFG, 0, 32'h08, p);
    #Q chk("R3 irq back on", {31'b0, irq}, 1);
    pf = 0; wait_cycles(5);
    rd(SEL_BUS, K_AUX2, 0, d); chk("R4 fall clears", d, 0);
    #Q chk("R3 irq after fall", {31'b0, irq}, 0);
    wr(SEL_BUS, K_CFG, 0, 32'h00, p);
    pf = 1; wait_cycles(5);
    rd(SEL_BUS, K_AUX2, 0, d); chk("R4 rise without enable", d, 0);
    pf = 0; wait_cycles(5);
  endtask

  task automatic t_aux2_writes();
    logic [31:0] d; logic [2:0] p;
    wr(SEL_BUS, K_CFG, 0, 32'h08, p);
    pf = 1; wait_cycles(5);
    wr(SEL_BUS, K_AUX2, 0, 32'h01, p);
    chk("R6 shutdown pulse", {29'b0, p}, 3'b100);
    #Q chk("R6 shutdown one cycle", {31'b0, shut}, 0);
    rd(SEL_BUS, K_AUX2, 0, d); chk("R5 bit2 kept bit0 set", d, 32'h05);
    wr(SEL_BUS, K_AUX2, 0, 32'h00, p);
    chk("R6 no shutdown bit0 clear", {29'b0, p}, 0);
    rd(SEL_BUS, K_AUX2, 0, d); chk("R5 bit0 clear keeps bit2", d, 32'h04);
    wr(SEL_BUS, K_AUX2, 0, 32'h02, p);
    rd(SEL_BUS, K_AUX2, 0, d); chk("R5 clear bit", d, 0);
    #Q chk("R3 irq after clear", {31'b0, irq}, 0);
    wr(SEL_BUS, K_AUX2, 0, 32'hFD, p);
    rd(SEL_BUS, K_AUX2, 0, d); chk("R5 only low two bits", d, 32'h01);
    wr(SEL_BUS, K_AUX2, 0, 32'h03, p);
    chk("R6 shutdown with clear", {29'b0, p}, 3'b100);
    rd(SEL_BUS, K_AUX2, 0, d); chk("R5 clear leaves bit0", d, 32'h01);
    pf = 0; wait_cycles(5);
  endtask

  task automatic t_clear_wins();
    logic [31:0] d;
    @(negedge clk);
    drive(SEL_BUS, K_AUX2, 0); wr_en = 1; wdata = 32'h02; pf = 1;
    wait_cycles(6);
    idle();
    rd(SEL_BUS, K_AUX2, 0, d); chk("R10 software clear wins", d, 0);
    #Q chk("R10 irq stays low", {31'b0, irq}, 0);
    pf = 0; wait_cycles(5);
  endtask

  task automatic t_halt();
    logic [2:0] p;
    wr(SEL_PM, 12'h0, 0, 32'h0, p);
    chk("R7 halt pulse", {29'b0, p}, 3'b001);
    #Q chk("R7 halt one cycle", {31'b0, halt}, 0);
  endtask

  task automatic t_sysctrl();
    logic [31:0] d; logic [2:0] p;
    wr(SEL_SYS, 12'h0, 0, 32'h1, p);
    chk("R9 reset request pulse", {29'b0, p}, 3'b010);
    rd(SEL_SYS, 12'h0, 0, d); chk("R9 loads 0x2", d, 32'h2);
    wr(SEL_SYS, 12'h0, 0, 32'hFFFF_FFFE, p);
    chk("R9 bit0 clear no pulse", {29'b0, p}, 0);
    rd(SEL_SYS, 12'h0, 0, d); chk("R9 bit0 clear no change", d, 32'h2);
    wr(SEL_SYS, 12'h0, 1, 32'h1, p);
    chk("R9 other offset no pulse", {29'b0, p}, 0);
    rd(SEL_SYS, 12'h0, 1, d); chk("R2 R9 other offset reads zero", d, 0);
  endtask

  task automatic t_selective_reset();
    logic [31:0] d; logic [2:0] p;
    wr(SEL_BUS, K_CFG, 0, 32'h08, p);
    wr(SEL_BUS, K_AUX1, 0, 32'h77, p);
    wr(SEL_BUS, K_AUX2, 0, 32'h01, p);
    wr(SEL_BUS, K_MDM, 0, 32'h99, p);
    wr(SEL_BUS, K_DIAG, 0, 32'h6E, p);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(SEL_BUS, K_CFG, 0, d);  chk("R8 cfg cleared", d, 0);
    rd(SEL_BUS, K_AUX1, 0, d); chk("R8 aux1 cleared", d, 0);
    rd(SEL_BUS, K_AUX2, 0, d); chk("R8 aux2 cleared", d, 0);
    rd(SEL_BUS, K_MDM, 0, d);  chk("R8 mdm cleared", d, 0);
    rd(SEL_BUS, K_DIAG, 0, d); chk("R8 diag kept", d, 32'h6E);
    rd(SEL_SYS, 12'h0, 0, d);  chk("R8 sysctrl kept", d, 32'h2);
  endtask

  initial begin
    wait_cycles(3);
    rst_n = 1;
    t_reset_state();
    t_readback();
    t_unmapped();
    t_power_fail();
    t_aux2_writes();
    t_clear_wins();
    t_halt();
    t_sysctrl();
    t_selective_reset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule